// File: doc/BRIEF.md
# UART Receive/Transmit FIFO Pair with Fill-Level Interrupt

This block holds the character buffers that sit between a UART's serial engine and the host bus. Bytes from the receiver enter a receive FIFO and leave through host reads of the data register. Bytes written by the host enter a transmit FIFO and leave when the transmitter pops them. A control bit picks between 16-entry FIFOs and one-entry holding registers. A flag register shows the empty and full state of both buffers.

A receive interrupt latches when the receive fill level first reaches a selectable fraction of the depth. It is gated by a mask bit. A host write-one-to-clear drops it, and so does a fill level that falls back under the threshold. A test mode gives the host two extra paths. It can push bytes straight into the receive FIFO, and its data reads then pop the transmit FIFO. Software can use these paths to pre-load the receive FIFO to one below the threshold, so that a single external byte raises the interrupt.

The register index (`bus_addr`) decodes as follows: 0 data, 1 flags, 2 control, 3 level select, 4 mask, 5 clear, 6 test control, 7 test data. Writes take effect on the clock edge. Read data is combinational for the presented index, and a data-register read pops its FIFO on the same edge.

Top module: `uart_fifo_irq`

## Requirements
- R1: After reset the flags read 0x90. FIFO mode, level select, mask and test mode are all 0, `rx_irq` is 0, `tx_avail` is 0 and `tx_data` is 0.
- R2: With control bit 0 set, each FIFO holds 16 bytes in first-in first-out order. Transmit-full is set when 16 bytes are held.
- R3: With control bit 0 clear, each direction holds one byte. Full is set when that byte is present, and the receive threshold is 1 byte.
- R4: The flags register reads transmit-empty at bit 7, transmit-full at bit 5 and receive-empty at bit 4. All other bits read 0.
- R5: Level-select codes 0, 1, 2, 3 and 4 set a threshold of 2, 4, 8, 12 and 14 bytes (1/8, 1/4, 1/2, 3/4 and 7/8 of depth). Codes 5 to 7 act as code 4.
- R6: The pending interrupt sets one cycle after the receive fill level rises from below the threshold to at or above it. It stays set until a clear-register write with bit 4 set, or until the level drops below the threshold. Other clear bits have no effect.
- R7: `rx_irq` is the pending bit gated by mask bit 4. Mask 1 enables the output and mask 0 blocks it.
- R8: With test bit 1 set, a test-data write pushes its low byte into the receive FIFO, and a data read pops the transmit FIFO. With test bit 1 clear, a test-data write changes nothing.
- R9: A push to a full FIFO is dropped. A read of an empty FIFO returns 0. Neither changes the stored contents or their order.
- R10: `rx_valid` pushes `rx_data` into the receive FIFO. `tx_data` shows the transmit head (0 when empty), `tx_avail` is high while the transmit FIFO is not empty, and `tx_pop` removes the head. An external receive byte takes precedence over a test-data write in the same cycle.
- R11: A control write that changes bit 0 empties both FIFOs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 3 | Register index |
| bus_wr | input | 1 | Register write strobe |
| bus_wdata | input | 16 | Write data |
| bus_rd | input | 1 | Register read strobe (pops on data reads) |
| bus_rdata | output | 16 | Read data for the presented index |
| rx_valid | input | 1 | Received byte strobe from the serial receiver |
| rx_data | input | 8 | Received byte |
| tx_pop | input | 1 | Transmitter takes the head byte |
| tx_data | output | 8 | Transmit FIFO head byte |
| tx_avail | output | 1 | Transmit FIFO holds a byte |
| rx_irq | output | 1 | Masked receive-level interrupt |

## Verification
A corrupted pointer or count shows up at the ports within one access. It appears as a wrong byte at `tx_data`, as a wrong data-register read, or as a wrong empty or full flag on the next flags read. A fault in the threshold or the crossing latch shows up one cycle after the byte that should have crossed the threshold. The bench pre-loads threshold-minus-one bytes, checks that `rx_irq` is still low, and then sends the crossing byte. This places the fault on a single edge. Lost clears and lost level-drop releases show up as `rx_irq` still high right after the write or the read that should have dropped it.

// File: rtl/ufq_pkg.sv
package ufq_pkg;
  typedef enum logic [2:0] {
    A_DATA = 3'd0,
    A_FLAG = 3'd1,
    A_CTRL = 3'd2,
    A_LVL  = 3'd3,
    A_MASK = 3'd4,
    A_CLR  = 3'd5,
    A_TCTL = 3'd6,
    A_TDAT = 3'd7
  } ufq_addr_e;

  localparam int FLG_TXE    = 7;
  localparam int FLG_TXF    = 5;
  localparam int FLG_RXE    = 4;
  localparam int RX_IRQ_BIT = 4;
  localparam int TEST_BIT   = 1;
  localparam int BUS_W      = 16;
  localparam int BYTE_W     = 8;
endpackage

// File: rtl/ufq_fifo.sv
module ufq_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          single,
  input  logic          flush,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  dout,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [CW-1:0] cnt_q, cnt_d, cap;
  logic          do_push, do_pop;

  assign cap     = single ? CW'(1) : CW'(DEPTH);
  assign full    = (cnt_q == cap);
  assign empty   = (cnt_q == '0);
  assign do_push = push & ~full & ~flush;
  assign do_pop  = pop & ~empty & ~flush;
  assign count   = cnt_q;
  assign dout    = empty ? '0 : mem[rd_q];

  always_comb begin
    wr_d  = wr_q;
    rd_d  = rd_q;
    cnt_d = cnt_q;
    if (flush) begin
      wr_d  = '0;
      rd_d  = '0;
      cnt_d = '0;
    end else begin
      if (do_push) wr_d = wr_q + AW'(1);
      if (do_pop)  rd_d = rd_q + AW'(1);
      case ({do_push, do_pop})
        2'b10:   cnt_d = cnt_q + CW'(1);
        2'b01:   cnt_d = cnt_q - CW'(1);
        default: cnt_d = cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_q] <= din;
  end

  // R2 R3
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= cap);

  // R9
  drop_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop && !flush) |=> $stable(cnt_q) && $stable(wr_q));

  // R9
  empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && empty && !push && !flush) |=> $stable(rd_q) && (cnt_q == '0));
endmodule

// File: rtl/ufq_lvl_irq.sv
module ufq_lvl_irq #(
  parameter int DEPTH = 16,
  localparam int CW   = $clog2(DEPTH) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] count,
  input  logic          fifo_en,
  input  logic [2:0]    lvl_sel,
  input  logic          mask,
  input  logic          clr,
  output logic          irq
);
  localparam logic [CW-1:0] T_EIGHTH = CW'(DEPTH / 8);
  localparam logic [CW-1:0] T_QUART  = CW'(DEPTH / 4);
  localparam logic [CW-1:0] T_HALF   = CW'(DEPTH / 2);
  localparam logic [CW-1:0] T_3QUART = CW'((3 * DEPTH) / 4);
  localparam logic [CW-1:0] T_7EIGHT = CW'((7 * DEPTH) / 8);

  logic [CW-1:0] thr;
  logic          at_lvl, prev_q, pend_q, pend_d;

  always_comb begin
    if (!fifo_en) thr = CW'(1);
    else begin
      case (lvl_sel)
        3'd0:    thr = T_EIGHTH;
        3'd1:    thr = T_QUART;
        3'd2:    thr = T_HALF;
        3'd3:    thr = T_3QUART;
        default: thr = T_7EIGHT;
      endcase
    end
  end

  assign at_lvl = (count >= thr);

  always_comb begin
    if (at_lvl && !prev_q)     pend_d = 1'b1;
    else if (!at_lvl || clr)   pend_d = 1'b0;
    else                       pend_d = pend_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      prev_q <= at_lvl;
      pend_q <= pend_d;
    end
  end

  assign irq = pend_q & mask;

  // R6
  crossing_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (at_lvl && !prev_q) |=> pend_q);

  // R6
  below_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!at_lvl) |=> !pend_q);
endmodule

// File: rtl/uart_fifo_irq.sv
module uart_fifo_irq
  import ufq_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CW   = $clog2(DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        bus_addr,
  input  logic              bus_wr,
  input  logic [BUS_W-1:0]  bus_wdata,
  input  logic              bus_rd,
  output logic [BUS_W-1:0]  bus_rdata,
  input  logic              rx_valid,
  input  logic [BYTE_W-1:0] rx_data,
  input  logic              tx_pop,
  output logic [BYTE_W-1:0] tx_data,
  output logic              tx_avail,
  output logic              rx_irq
);
  logic [1:0] rst_sync_q;
  logic       srst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign srst_n = rst_sync_q[1];

  ufq_addr_e  addr;
  logic       fifo_en_q, fifo_en_d, mask_q, mask_d, test_q, test_d;
  logic [2:0] lvl_q, lvl_d;
  logic       flush, clr;
  logic       rx_push, rx_pop, tx_push, tx_pop_i;
  logic [BYTE_W-1:0] rx_din, rx_dout, tx_dout;
  logic [CW-1:0] rx_cnt, tx_cnt;
  logic       rx_full, rx_empty, tx_full, tx_empty;

  assign addr = ufq_addr_e'(bus_addr);

  always_comb begin
    fifo_en_d = fifo_en_q;
    lvl_d     = lvl_q;
    mask_d    = mask_q;
    test_d    = test_q;
    if (bus_wr) begin
      case (addr)
        A_CTRL:  fifo_en_d = bus_wdata[0];
        A_LVL:   lvl_d     = bus_wdata[2:0];
        A_MASK:  mask_d    = bus_wdata[RX_IRQ_BIT];
        A_TCTL:  test_d    = bus_wdata[TEST_BIT];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      fifo_en_q <= 1'b0;
      lvl_q     <= 3'd0;
      mask_q    <= 1'b0;
      test_q    <= 1'b0;
    end else begin
      fifo_en_q <= fifo_en_d;
      lvl_q     <= lvl_d;
      mask_q    <= mask_d;
      test_q    <= test_d;
    end
  end

  assign flush    = bus_wr && (addr == A_CTRL) && (bus_wdata[0] != fifo_en_q);
  assign clr      = bus_wr && (addr == A_CLR) && bus_wdata[RX_IRQ_BIT];
  assign rx_push  = rx_valid || (bus_wr && test_q && (addr == A_TDAT));
  assign rx_din   = rx_valid ? rx_data : bus_wdata[BYTE_W-1:0];
  assign rx_pop   = bus_rd && (addr == A_DATA) && !test_q;
  assign tx_push  = bus_wr && (addr == A_DATA);
  assign tx_pop_i = tx_pop || (bus_rd && (addr == A_DATA) && test_q);

  ufq_fifo #(.W(BYTE_W), .DEPTH(DEPTH)) u_rx (
    .clk(clk), .rst_n(srst_n), .single(!fifo_en_q), .flush(flush),
    .push(rx_push), .din(rx_din), .pop(rx_pop), .dout(rx_dout),
    .count(rx_cnt), .full(rx_full), .empty(rx_empty));

  ufq_fifo #(.W(BYTE_W), .DEPTH(DEPTH)) u_tx (
    .clk(clk), .rst_n(srst_n), .single(!fifo_en_q), .flush(flush),
    .push(tx_push), .din(bus_wdata[BYTE_W-1:0]), .pop(tx_pop_i), .dout(tx_dout),
    .count(tx_cnt), .full(tx_full), .empty(tx_empty));

  ufq_lvl_irq #(.DEPTH(DEPTH)) u_irq (
    .clk(clk), .rst_n(srst_n), .count(rx_cnt), .fifo_en(fifo_en_q),
    .lvl_sel(lvl_q), .mask(mask_q), .clr(clr), .irq(rx_irq));

  always_comb begin
    bus_rdata = '0;
    case (addr)
      A_DATA: bus_rdata[BYTE_W-1:0] = test_q ? tx_dout : rx_dout;
      A_FLAG: begin
        bus_rdata[FLG_TXE] = tx_empty;
        bus_rdata[FLG_TXF] = tx_full;
        bus_rdata[FLG_RXE] = rx_empty;
      end
      A_CTRL: bus_rdata[0]          = fifo_en_q;
      A_LVL:  bus_rdata[2:0]        = lvl_q;
      A_MASK: bus_rdata[RX_IRQ_BIT] = mask_q;
      A_TCTL: bus_rdata[TEST_BIT]   = test_q;
      default: ;
    endcase
  end

  assign tx_data  = tx_dout;
  assign tx_avail = !tx_empty;

  logic unused_bits;
  assign unused_bits = ^{bus_wdata[BUS_W-1:BYTE_W], tx_cnt, rx_full};

  // R8
  test_off_ignore_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (bus_wr && (addr == A_TDAT) && !test_q && !rx_valid && !bus_rd) |=> $stable(rx_cnt));

  // R7
  mask_gate_chk: assert property (@(posedge clk) disable iff (!srst_n)
    !mask_q |-> !rx_irq);
endmodule

// File: tb/sim_uart_fifo_irq.sv
module sim_uart_fifo_irq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic        bus_rd = 1'b0;
  logic [15:0] bus_rdata;
  logic        rx_valid = 1'b0;
  logic [7:0]  rx_data = '0;
  logic        tx_pop = 1'b0;
  logic [7:0]  tx_data;
  logic        tx_avail;
  logic        rx_irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  uart_fifo_irq u0 (.*);

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    bus_addr = 3'(a); bus_wdata = 16'(d); bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input int a, output int v);
    @(negedge clk);
    bus_addr = 3'(a); bus_rd = 1'b1;
    #1 v = int'(bus_rdata);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic ext_rx(input int b);
    @(negedge clk);
    rx_valid = 1'b1; rx_data = 8'(b);
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic pop_tx();
    @(negedge clk);
    tx_pop = 1'b1;
    @(negedge clk);
    tx_pop = 1'b0;
  endtask

  task automatic settle();
    @(negedge clk);
  endtask

  task automatic restart(input int fen);
    wr(2, fen ? 0 : 1);
    wr(2, fen);
  endtask

  task automatic t_reset();
    int v;
    rd(1, v); chk("R1 R4 flags", v, 'h90);
    rd(2, v); chk("R1 ctrl", v, 0);
    rd(4, v); chk("R1 mask", v, 0);
    rd(6, v); chk("R1 test", v, 0);
    chk("R1 irq", rx_irq, 0);
    chk("R1 tx_avail", tx_avail, 0);
    chk("R1 tx_data", tx_data, 0);
  endtask

  task automatic t_depth();
    int v;
    restart(1);
    for (int i = 0; i < 16; i++) wr(0, i * 3 + 1);
    rd(1, v); chk("R2 R4 flags full", v, 'h30);
    wr(0, 'hEE);
    for (int i = 0; i < 16; i++) begin
      chk("R2 R10 tx order", tx_data, i * 3 + 1);
      pop_tx();
    end
    chk("R9 R10 tx dropped", tx_avail, 0);
    chk("R10 tx_data empty", tx_data, 0);
    wr(6, 2);
    for (int i = 0; i < 17; i++) wr(7, 'h20 + i);
    wr(6, 0);
    for (int i = 0; i < 16; i++) begin
      rd(0, v); chk("R2 R8 rx order", v, 'h20 + i);
    end
    rd(0, v); chk("R9 empty read", v, 0);
    rd(1, v); chk("R9 flags after", v, 'h90);
  endtask

  task automatic t_holding();
    int v;
    restart(0);
    wr(4, 16); wr(5, 'h7FF);
    ext_rx('h55); settle();
    chk("R3 irq one byte", rx_irq, 1);
    ext_rx('h66);
    rd(0, v); chk("R3 holding rx", v, 'h55);
    rd(0, v); chk("R3 R9 second dropped", v, 0);
    chk("R6 level drop release", rx_irq, 0);
    wr(0, 'h11); wr(0, 'h22);
    rd(1, v); chk("R3 R4 tx full", v, 'h30);
    chk("R3 tx head", tx_data, 'h11);
    pop_tx();
    chk("R3 R9 tx empty", tx_avail, 0);
  endtask

  task automatic t_levels();
    int thr [6] = '{2, 4, 8, 12, 14, 14};
    for (int c = 0; c < 6; c++) begin
      restart(1);
      wr(3, c); wr(4, 16); wr(5, 'h7FF);
      wr(6, 2);
      for (int i = 0; i < thr[c] - 1; i++) wr(7, 'h40 + i);
      wr(6, 0);
      settle();
      chk($sformatf("R5 below code %0d", c), rx_irq, 0);
      ext_rx('h7E); settle();
      chk($sformatf("R5 R6 cross code %0d", c), rx_irq, 1);
    end
  endtask

  task automatic t_clear_mask();
    int v;
    restart(1);
    wr(3, 0); wr(4, 0); wr(5, 'h7FF);
    ext_rx('h01); ext_rx('h02); settle();
    chk("R7 masked", rx_irq, 0);
    wr(4, 16);
    chk("R7 unmasked", rx_irq, 1);
    wr(5, 'h001);
    chk("R6 other bit no effect", rx_irq, 1);
    wr(5, 'h010);
    chk("R6 w1c", rx_irq, 0);
    ext_rx('h03); settle();
    chk("R6 no re-cross", rx_irq, 0);
    rd(0, v); chk("R2 read 1", v, 'h01);
    rd(0, v); chk("R2 read 2", v, 'h02);
    ext_rx('h04); settle();
    chk("R6 re-cross", rx_irq, 1);
  endtask

  task automatic t_test_mode();
    int v;
    restart(1);
    wr(7, 'h77);
    rd(1, v); chk("R8 test-off ignored", v, 'h90);
    wr(0, 'hA1); wr(0, 'hB2);
    chk("R10 tx head", tx_data, 'hA1);
    wr(6, 2);
    rd(0, v); chk("R8 tx read 1", v, 'hA1);
    rd(0, v); chk("R8 tx read 2", v, 'hB2);
    rd(0, v); chk("R8 R9 tx empty read", v, 0);
    rd(1, v); chk("R8 flags", v, 'h90);
    wr(6, 0);
  endtask

  task automatic t_flush();
    int v;
    restart(1);
    wr(0, 'h5A);
    ext_rx('h3C);
    wr(2, 0);
    rd(1, v); chk("R11 flush", v, 'h90);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_depth();
    t_holding();
    t_levels();
    t_clear_mask();
    t_test_mode();
    t_flush();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule